// File: doc/BRIEF.md
# Multidrop 9-bit UART Node

This block is one node on a shared serial line where a single master addresses many slaves. Every frame on the line carries nine payload bits: eight data bits, least significant first, and a ninth flag bit that marks the frame as either an address (select-code) frame or a data frame. The frame begins with a low start bit and ends with a high stop bit. Every bit lasts a fixed number of oversampling ticks. The tick comes from an external baud generator.

The receiver synchronises the line and confirms the start bit at mid-bit, so short low glitches are rejected. It then samples each following bit at its centre. A wake-up filter sits behind the receiver. While the wake flag is set, the node listens only for an address frame that carries its own select code. When that frame arrives, the flag clears and the node from then on delivers every frame, including further address frames, with the flag bit visible. Software can raise the flag again with a one-cycle strobe. The transmitter sends a byte together with a flag bit chosen per frame. By default it refuses to start while the node is still listening, so a slave answers only after it has been selected.

Top module: `mdrop_uart_node`

## Requirements
- R1: A transmitted frame is start bit 0, data bits 0..7 LSB first, the flag bit, then stop bit 1. Each bit lasts OVS ticks. `tx_o` idles at 1 and `tx_busy_o` falls once the stop bit has completed.
- R2: A correctly framed received frame is presented on `rx_data_o`/`rx_flag_o` with a `rx_valid_o` pulse that lasts exactly one cycle.
- R3: A low pulse on `rx_i` shorter than half a bit produces neither `rx_valid_o` nor `rx_ferr_o`.
- R4: While `wake_o` is 1, a received frame with flag bit 0 is dropped and `wake_o` stays 1.
- R5: While `wake_o` is 1, an address frame (flag 1) whose byte equals `node_addr_i` clears `wake_o` and is delivered with `rx_flag_o`=1.
- R6: While `wake_o` is 1, an address frame whose byte differs from `node_addr_i` is dropped and `wake_o` stays 1.
- R7: While `wake_o` is 0, data frames and address frames are all delivered with the received flag bit, and `wake_o` stays 0.
- R8: A frame whose stop bit is 0 raises a one-cycle `rx_ferr_o`, is not delivered, and leaves `wake_o` unchanged.
- R9: A one-cycle `wake_set_i` sets `wake_o` to 1. If it comes in the same cycle as a hardware clear from a matching address frame, `wake_o` ends at 1.
- R10: With the transmit gate enabled (default), a `tx_start_i` while `wake_o` is 1 is ignored: `tx_o` stays 1 and `tx_busy_o` stays 0.
- R11: A `tx_start_i` while `tx_busy_o` is 1 is ignored, and the frame in progress completes unchanged.
- R12: After reset `wake_o`=1, `tx_o`=1, `tx_busy_o`=0, `rx_valid_o`=0 and `rx_ferr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, OVS per bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| tx_start_i | input | 1 | Request to send one frame |
| tx_data_i | input | DW | Byte to send |
| tx_flag_i | input | 1 | Ninth bit to send (1 = address) |
| tx_busy_o | output | 1 | Transmitter sending |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered frame |
| rx_data_o | output | DW | Delivered byte |
| rx_flag_o | output | 1 | Delivered ninth bit |
| rx_ferr_o | output | 1 | One-cycle strobe for a stop-bit error |
| node_addr_i | input | DW | This node's select code |
| wake_set_i | input | 1 | Strobe that re-enters listening mode |
| wake_o | output | 1 | Wake flag (1 = listening) |

## Verification
The assertions check the filter decisions on every cycle. Each completed frame is checked for being dropped or delivered and for its effect on the wake flag, including framing errors and the priority of the software strobe over a hardware clear. They also check that the receive strobe is a single pulse and that the transmit gate and start bit behave correctly. The bench's scenarios are the only check of serial timing that a property cannot see: mid-bit sampling, glitch rejection, bit order on the wire, and the full sweep of all 256 select codes against one node address.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   // Value of the line between frames and the stop level.
   localparam logic LINE_IDLE = 1'b1;
   localparam logic LINE_START = 1'b0;

endpackage

// File: rtl/mdu_rx.sv
module mdu_rx
   import mdu_pkg::*;
#(
   parameter int DW   = 8,
   parameter int OVS  = 16,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rx_i,
   output logic          done_o,
   output logic          stop_ok_o,
   output logic [DW-1:0] data_o,
   output logic          flag_o
);
   localparam int CW = $clog2(OVS);
   localparam int NB = DW + 1;
   localparam int BW = $clog2(NB + 1);
   localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
   localparam logic [BW-1:0] LAST_B  = BW'(NB - 1);

   logic [SYNC-1:0] sy;
   logic            rx_s;

   generate
      if (SYNC == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy <= '1;
            else        sy <= rx_i;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy <= '1;
            else        sy <= {sy[SYNC-2:0], rx_i};
         end
      end
   endgenerate

   assign rx_s = sy[SYNC-1];

   rx_state_e      st;
   logic [CW-1:0]  cnt;
   logic [BW-1:0]  bidx;
   logic [NB-1:0]  sh;
   logic           done_q;
   logic           stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         sh     <= '0;
         done_q <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (rx_s == LINE_START) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == HALF_M1) begin
                     cnt  <= '0;
                     bidx <= '0;
                     st   <= (rx_s == LINE_START) ? RX_BITS : RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt == FULL_M1) begin
                     cnt <= '0;
                     sh  <= {rx_s, sh[NB-1:1]};
                     if (bidx == LAST_B) st <= RX_STOP;
                     else                bidx <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == FULL_M1) begin
                     cnt    <= '0;
                     done_q <= 1'b1;
                     stop_q <= rx_s;
                     st     <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign stop_ok_o = stop_q;
   assign data_o    = sh[DW-1:0];
   assign flag_o    = sh[DW];

   // R2: a completed frame is reported for a single cycle
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/mdu_wake_filter.sv
module mdu_wake_filter #(
   parameter int   DW       = 8,
   parameter logic WAKE_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done_i,
   input  logic          stop_ok_i,
   input  logic [DW-1:0] data_i,
   input  logic          flag_i,
   input  logic [DW-1:0] addr_i,
   input  logic          wake_set_i,
   output logic          valid_o,
   output logic [DW-1:0] data_o,
   output logic          flag_o,
   output logic          ferr_o,
   output logic          wake_o
);
   logic          wake_q;
   logic          valid_q;
   logic          ferr_q;
   logic [DW-1:0] data_q;
   logic          flag_q;
   logic          good;
   logic          match;
   logic          pass;
   logic          hw_clear;

   assign good     = done_i && stop_ok_i;
   assign match    = flag_i && (data_i == addr_i);
   assign pass     = !wake_q || match;
   assign hw_clear = good && wake_q && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         data_q  <= '0;
         flag_q  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         if (done_i && !stop_ok_i) begin
            ferr_q <= 1'b1;
         end else if (good && pass) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
            flag_q  <= flag_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wake_q <= WAKE_RST;
      else if (wake_set_i) wake_q <= 1'b1;
      else if (hw_clear)   wake_q <= 1'b0;
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
   assign flag_o  = flag_q;
   assign ferr_o  = ferr_q;
   assign wake_o  = wake_q;

   // R4: data frames are dropped while listening
   a_r4_drop_data: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && stop_ok_i && wake_q && !flag_i && !wake_set_i) |=> (!valid_q && wake_q));

   // R5: own select code wakes the node and is delivered
   a_r5_match_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && stop_ok_i && wake_q && flag_i && data_i == addr_i && !wake_set_i)
      |=> (!wake_q && valid_q && flag_q));

   // R6: foreign select code is dropped while listening
   a_r6_foreign_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && stop_ok_i && wake_q && flag_i && data_i != addr_i && !wake_set_i)
      |=> (!valid_q && wake_q));

   // R7: awake node delivers every good frame
   a_r7_awake_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && stop_ok_i && !wake_q && !wake_set_i) |=> (valid_q && !wake_q));

   // R8: stop-bit error is flagged, not delivered, wake untouched
   a_r8_ferr: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !stop_ok_i && !wake_set_i) |=> (ferr_q && !valid_q && $stable(wake_q)));

   // R9: software set wins
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wake_set_i |=> wake_q);

endmodule

// File: rtl/mdu_tx.sv
module mdu_tx #(
   parameter int DW      = 8,
   parameter int OVS     = 16,
   parameter bit GATE_TX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start_i,
   input  logic [DW-1:0] data_i,
   input  logic          flag_i,
   input  logic          wake_i,
   output logic          tx_o,
   output logic          busy_o
);
   localparam int CW = $clog2(OVS);
   localparam int NF = DW + 3;
   localparam int FW = $clog2(NF + 1);
   localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

   logic          accept;
   logic          busy_q;
   logic [NF-1:0] sh;
   logic [CW-1:0] cnt;
   logic [FW-1:0] left;

   generate
      if (GATE_TX) begin : g_gated
         assign accept = start_i && !busy_q && !wake_i;

         // R10: a listening node never starts a frame
         a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (start_i && wake_i && !busy_q) |=> (!busy_q && tx_o));
      end else begin : g_open
         logic unused_wake;
         assign unused_wake = wake_i;
         assign accept = start_i && !busy_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh     <= '1;
         cnt    <= '0;
         left   <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         sh     <= {1'b1, flag_i, data_i, 1'b0};
         cnt    <= '0;
         left   <= FW'(NF);
      end else if (busy_q && tick) begin
         if (cnt == FULL_M1) begin
            cnt <= '0;
            sh  <= {1'b1, sh[NF-1:1]};
            if (left == FW'(1)) busy_q <= 1'b0;
            left <= left - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign tx_o   = busy_q ? sh[0] : 1'b1;
   assign busy_o = busy_q;

   // R1: the first cycle of a frame drives the start level
   a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !tx_o);

   // R11: a request during a frame does not restart it
   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !(tick && cnt == FULL_M1)) |=> $stable(sh));

endmodule

// File: rtl/mdrop_uart_node.sv
module mdrop_uart_node #(
   parameter int   DW       = 8,
   parameter int   OVS      = 16,
   parameter int   SYNC     = 2,
   parameter bit   GATE_TX  = 1'b1,
   parameter logic WAKE_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          rx_i,
   output logic          tx_o,
   input  logic          tx_start_i,
   input  logic [DW-1:0] tx_data_i,
   input  logic          tx_flag_i,
   output logic          tx_busy_o,
   output logic          rx_valid_o,
   output logic [DW-1:0] rx_data_o,
   output logic          rx_flag_o,
   output logic          rx_ferr_o,
   input  logic [DW-1:0] node_addr_i,
   input  logic          wake_set_i,
   output logic          wake_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
      if (SYNC < 1) begin : g_bad_sync
         $error("SYNC must be at least 1");
      end
   endgenerate

   logic          fr_done;
   logic          fr_stop_ok;
   logic [DW-1:0] fr_data;
   logic          fr_flag;

   mdu_rx #(.DW(DW), .OVS(OVS), .SYNC(SYNC)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .rx_i      (rx_i),
      .done_o    (fr_done),
      .stop_ok_o (fr_stop_ok),
      .data_o    (fr_data),
      .flag_o    (fr_flag)
   );

   mdu_wake_filter #(.DW(DW), .WAKE_RST(WAKE_RST)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (fr_done),
      .stop_ok_i  (fr_stop_ok),
      .data_i     (fr_data),
      .flag_i     (fr_flag),
      .addr_i     (node_addr_i),
      .wake_set_i (wake_set_i),
      .valid_o    (rx_valid_o),
      .data_o     (rx_data_o),
      .flag_o     (rx_flag_o),
      .ferr_o     (rx_ferr_o),
      .wake_o     (wake_o)
   );

   mdu_tx #(.DW(DW), .OVS(OVS), .GATE_TX(GATE_TX)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .start_i (tx_start_i),
      .data_i  (tx_data_i),
      .flag_i  (tx_flag_i),
      .wake_i  (wake_o),
      .tx_o    (tx_o),
      .busy_o  (tx_busy_o)
   );

   // R2: delivery strobe is a single-cycle pulse
   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

endmodule

// File: tb/tb_mdrop_uart_node.sv
module tb_mdrop_uart_node;
   localparam int DW  = 8;
   localparam int OVS = 16;
   localparam logic [7:0] ADDR = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b1;
   logic rx_i = 1'b1;
   logic tx_o;
   logic tx_start_i = 1'b0;
   logic [DW-1:0] tx_data_i = '0;
   logic tx_flag_i = 1'b0;
   logic tx_busy_o;
   logic rx_valid_o;
   logic [DW-1:0] rx_data_o;
   logic rx_flag_o;
   logic rx_ferr_o;
   logic [DW-1:0] node_addr_i = ADDR;
   logic wake_set_i = 1'b0;
   logic wake_o;

   int n_run = 0;
   int n_fail = 0;
   int vcnt = 0;
   int fcnt = 0;
   logic [7:0] vdata;
   logic vflag;

   always #2.5 clk = ~clk;

   mdrop_uart_node dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_i(rx_i), .tx_o(tx_o),
      .tx_start_i(tx_start_i), .tx_data_i(tx_data_i), .tx_flag_i(tx_flag_i),
      .tx_busy_o(tx_busy_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
      .rx_flag_o(rx_flag_o), .rx_ferr_o(rx_ferr_o), .node_addr_i(node_addr_i),
      .wake_set_i(wake_set_i), .wake_o(wake_o)
   );

   always @(negedge clk) begin
      if (rx_valid_o) begin
         vcnt  <= vcnt + 1;
         vdata <= rx_data_o;
         vflag <= rx_flag_o;
      end
      if (rx_ferr_o) fcnt <= fcnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic frame_bit(input logic [7:0] d, input logic f, input logic s, input int i);
      if (i == 0) return 1'b0;
      if (i <= 8) return d[i-1];
      if (i == 9) return f;
      return s;
   endfunction

   // Drives one frame starting at a negedge; strobe wake_set at cycle set_at.
   task automatic send_frame(input logic [7:0] d, input logic f, input logic s, input int set_at);
      for (int j = 0; j < 11 * OVS; j++) begin
         @(negedge clk);
         rx_i = frame_bit(d, f, s, j / OVS);
         wake_set_i = (j == set_at);
      end
      @(negedge clk);
      rx_i = 1'b1;
      wake_set_i = 1'b0;
      repeat (24) @(negedge clk);
   endtask

   task automatic pulse_set();
      @(negedge clk);
      wake_set_i = 1'b1;
      @(negedge clk);
      wake_set_i = 1'b0;
   endtask

   // Start a transmission and decode tx_o; optionally inject a second request.
   task automatic tx_decode(input logic [7:0] d, input logic f, input bit inject, input string req);
      logic [10:0] got;
      @(negedge clk);
      tx_data_i = d;
      tx_flag_i = f;
      tx_start_i = 1'b1;
      for (int j = 0; j < 11 * OVS; j++) begin
         @(negedge clk);
         if (j == 0) tx_start_i = 1'b0;
         if (inject && j == 30) begin
            tx_start_i = 1'b1;
            tx_data_i = ~d;
            tx_flag_i = ~f;
         end
         if (inject && j == 31) tx_start_i = 1'b0;
         if ((j % OVS) == OVS / 2) got[j / OVS] = tx_o;
      end
      @(negedge clk);
      chk(got == {1'b1, f, d, 1'b0}, req, got, {1'b1, f, d, 1'b0});
      chk(!tx_busy_o && tx_o, {req, " end"}, {tx_busy_o, tx_o}, 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int v0;
      int f0;
      repeat (5) @(negedge clk);
      // R12 reset state
      chk(wake_o == 1'b1 && tx_o == 1'b1 && !tx_busy_o && !rx_valid_o && !rx_ferr_o,
          "R12 reset", {wake_o, tx_o, tx_busy_o, rx_valid_o, rx_ferr_o}, 5'b11000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R5/R6 sweep of every select code while listening
      for (int c = 0; c < 256; c++) begin
         v0 = vcnt;
         send_frame(8'(c), 1'b1, 1'b1, -1);
         if (c == int'(ADDR)) begin
            chk(vcnt - v0 == 1 && !wake_o && vdata == ADDR && vflag,
                "R5 own code", {vcnt - v0, wake_o, vflag, vdata}, {1, 1'b0, 1'b1, ADDR});
            pulse_set();
         end else begin
            chk(vcnt == v0 && wake_o, "R6 foreign code", {vcnt - v0, wake_o}, 1);
         end
      end

      // R4 data frames while listening
      for (int k = 0; k < 4; k++) begin
         v0 = vcnt;
         send_frame(k == 0 ? ADDR : 8'(k * 77), 1'b0, 1'b1, -1);
         chk(vcnt == v0 && wake_o, "R4 data dropped", {vcnt - v0, wake_o}, 1);
      end

      // R8 bad stop on own address while listening
      v0 = vcnt; f0 = fcnt;
      send_frame(ADDR, 1'b1, 1'b0, -1);
      chk(vcnt == v0 && fcnt == f0 + 1 && wake_o, "R8 ferr listening",
          {vcnt - v0, fcnt - f0, wake_o}, {0, 1, 1'b1});

      // R3 short glitch
      v0 = vcnt; f0 = fcnt;
      @(negedge clk); rx_i = 1'b0;
      repeat (5) @(negedge clk);
      rx_i = 1'b1;
      repeat (40) @(negedge clk);
      chk(vcnt == v0 && fcnt == f0, "R3 glitch", {vcnt - v0, fcnt - f0}, 0);

      // R10 transmit refused while listening
      @(negedge clk); tx_data_i = 8'hC3; tx_flag_i = 1'b0; tx_start_i = 1'b1;
      @(negedge clk); tx_start_i = 1'b0;
      begin
         bit quiet = 1'b1;
         for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (!tx_o || tx_busy_o) quiet = 1'b0;
         end
         chk(quiet, "R10 gate", quiet, 1);
      end

      // R9 software set coincides with hardware clear (done acts at cycle 172)
      v0 = vcnt;
      send_frame(ADDR, 1'b1, 1'b1, 11 * OVS - 5);
      chk(wake_o && vcnt == v0 + 1, "R9 set priority", {wake_o, vcnt - v0}, {1'b1, 1});

      // wake the node
      send_frame(ADDR, 1'b1, 1'b1, -1);
      chk(!wake_o, "R5 wake cleared", wake_o, 0);

      // R7 / R2 data frames while awake
      for (int k = 0; k < 16; k++) begin
         logic [7:0] d;
         d = 8'((k * 17) ^ 8'h3C);
         v0 = vcnt;
         send_frame(d, 1'b0, 1'b1, -1);
         chk(vcnt == v0 + 1 && vdata == d && !vflag && !wake_o, "R7 R2 data delivered",
             {vcnt - v0, vflag, vdata}, {1, 1'b0, d});
      end
      v0 = vcnt;
      send_frame(8'h33, 1'b1, 1'b1, -1);
      chk(vcnt == v0 + 1 && vdata == 8'h33 && vflag && !wake_o, "R7 address while awake",
          {vcnt - v0, vflag, vdata, wake_o}, {1, 1'b1, 8'h33, 1'b0});

      // R8 bad stop while awake
      v0 = vcnt; f0 = fcnt;
      send_frame(8'h81, 1'b0, 1'b0, -1);
      chk(vcnt == v0 && fcnt == f0 + 1 && !wake_o, "R8 ferr awake",
          {vcnt - v0, fcnt - f0, wake_o}, {0, 1, 1'b0});

      // R1 transmit frames
      tx_decode(8'hA5, 1'b1, 1'b0, "R1 tx A5 addr");
      tx_decode(8'h01, 1'b0, 1'b0, "R1 tx 01 data");
      tx_decode(8'h80, 1'b1, 1'b0, "R1 tx 80 addr");
      // R11 request during busy ignored
      tx_decode(8'h6E, 1'b0, 1'b1, "R11 busy ignore");

      // R9 plain set from awake state
      pulse_set();
      @(negedge clk);
      chk(wake_o, "R9 strobe sets", wake_o, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule